// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block holds a rolling window of 32-bit trace frames in an on-chip RAM whose depth is a parameter. While capture is enabled, each valid frame is written at the write pointer. The pointer then advances and wraps back to address zero after the last location. A sticky flag records that the pointer has wrapped at least once, which means older frames have been overwritten.

A host reads the buffer through a register-style port. It loads a read pointer and then issues read strobes. Each strobe returns the word at the read pointer one cycle later and steps the pointer forward, modulo the depth. The host chooses where to start from the exposed write pointer and status:

- Without a wrap, the oldest frame is at address 0.
- After a wrap, the oldest frame is at the write pointer.
- The newest frame is always one location behind the write pointer.

A full readout of DEPTH words therefore returns the window oldest-first. A re-arm strobe starts a fresh capture.

Top module: `trace_ring_buf`

## Requirements
- R1: After reset, `wr_ptr` is 0, `status` is 2'b00 and `rd_valid` is 0.
- R2: When `cap_en` and `cap_valid` are both 1 and `arm` is 0, `cap_data` is stored at `wr_ptr`, and `wr_ptr` increases by one on the next cycle. When `cap_en` is 0, a `cap_valid` pulse stores nothing and leaves `wr_ptr` unchanged.
- R3: A capture while `wr_ptr` equals DEPTH-1 sets `wr_ptr` to 0 and sets `status[1]` (overflow). The overflow bit then stays 1 until a re-arm.
- R4: `arm` clears `wr_ptr` to 0 and `status[1]` to 0 on the next cycle. A capture presented in the same cycle is dropped, and the RAM location it addressed keeps its old content.
- R5: `rd_ptr_load` loads `rd_ptr_val` into the read pointer. A `rd_req` in the same cycle is ignored, so `rd_valid` stays 0 on the next cycle.
- R6: A `rd_req` without `rd_ptr_load` returns the word at the read pointer on `rd_data`, with `rd_valid` = 1, on the next cycle. The read pointer then advances by one, wrapping from DEPTH-1 to 0.
- R7: A read whose address equals the address of a capture in the same cycle returns the word stored there before that capture.
- R8: Reading DEPTH words returns the captured frames oldest-first. Without an overflow the readout starts at address 0; with an overflow it starts at `wr_ptr`.
- R9: `status[0]` is 1 exactly when the buffer holds at least one frame since the last reset or re-arm, that is, when `wr_ptr` is non-zero or `status[1]` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable level |
| cap_valid | input | 1 | Frame present on cap_data this cycle |
| cap_data | input | 32 | Trace frame to store |
| arm | input | 1 | Re-arm strobe: clears write pointer and overflow |
| rd_ptr_load | input | 1 | Load the read pointer from rd_ptr_val |
| rd_ptr_val | input | AW | New read pointer value, AW = clog2(DEPTH) |
| rd_req | input | 1 | Read strobe for the data register |
| rd_data | output | 32 | Word read from the RAM |
| rd_valid | output | 1 | rd_data holds the result of last cycle's read |
| wr_ptr | output | AW | Current write pointer |
| status | output | 2 | bit 1 overflow, bit 0 non-empty |

## Verification
The assertions assume that every control input is a defined 0 or 1 from the first clock after reset, and that DEPTH is a power of two, so any `rd_ptr_val` names a real location. The stimulus drives every input from tasks at the falling edge and returns each strobe to 0 after one cycle. This covers the deliberate same-cycle cases: a load together with a read, a re-arm together with a capture, and a capture together with a read of the same address.

// File: rtl/trb_pkg.sv
package trb_pkg;
    parameter int unsigned TRB_WORD_W = 32;
endpackage

// File: rtl/trb_ram.sv
module trb_ram #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4,
    parameter int unsigned W     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] rdata_q;

    // storage: non-blocking update, so a same-cycle read sees the old word
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (re) begin
            rdata_q <= mem_q[raddr];
        end
    end

    assign rdata = rdata_q;

    // R6: the output register only moves when a read was issued
    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata_q));
endmodule

// File: rtl/trb_wr_ctrl.sv
module trb_wr_ctrl #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          cap_valid,
    input  logic          arm,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic          ovf
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          ovf;
    } wr_st_t;

    wr_st_t st_d, st_q;
    logic   cap;

    always_comb begin
        cap  = cap_en && cap_valid && !arm;
        st_d = st_q;
        if (arm) begin
            st_d.ptr = '0;
            st_d.ovf = 1'b0;
        end else if (cap) begin
            if (st_q.ptr == LAST) begin
                st_d.ptr = '0;
                st_d.ovf = 1'b1;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign we    = cap;
    assign waddr = st_q.ptr;
    assign ovf   = st_q.ovf;

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && cap_valid && !arm && st_q.ptr != LAST)
            |=> st_q.ptr == AW'($past(st_q.ptr) + 1'b1));
    assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cap_en && cap_valid) && !arm) |=> $stable(st_q.ptr));
    assert_wrap_sets_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && cap_valid && !arm && st_q.ptr == LAST)
            |=> (st_q.ptr == '0 && st_q.ovf));
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !arm) |=> st_q.ovf);
    assert_arm_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (st_q.ptr == '0 && !st_q.ovf));
    assert_no_write_on_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !we);
endmodule

// File: rtl/trb_rd_ctrl.sv
module trb_rd_ctrl #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_val,
    input  logic          rd_req,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic          rd_valid
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          vld;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic   do_rd;

    always_comb begin
        do_rd    = rd_req && !ptr_load;
        st_d     = st_q;
        st_d.vld = do_rd;
        if (ptr_load) begin
            st_d.ptr = ptr_val;
        end else if (do_rd) begin
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign re       = do_rd;
    assign raddr    = st_q.ptr;
    assign rd_valid = st_q.vld;

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> (st_q.ptr == $past(ptr_val) && !rd_valid));
    assert_read_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !ptr_load) |=> rd_valid);
    assert_read_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !ptr_load && st_q.ptr == LAST) |=> st_q.ptr == '0);
    assert_idle_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
endmodule

// File: rtl/trace_ring_buf.sv
module trace_ring_buf
    import trb_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_en,
    input  logic                  cap_valid,
    input  logic [TRB_WORD_W-1:0] cap_data,
    input  logic                  arm,
    input  logic                  rd_ptr_load,
    input  logic [AW-1:0]         rd_ptr_val,
    input  logic                  rd_req,
    output logic [TRB_WORD_W-1:0] rd_data,
    output logic                  rd_valid,
    output logic [AW-1:0]         wr_ptr,
    output logic [1:0]            status
);
    logic          we;
    logic [AW-1:0] waddr;
    logic          ovf;
    logic          re;
    logic [AW-1:0] raddr;

    trb_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_valid(cap_valid),
        .arm(arm), .we(we), .waddr(waddr), .ovf(ovf)
    );

    trb_rd_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .clk(clk), .rst_n(rst_n), .ptr_load(rd_ptr_load), .ptr_val(rd_ptr_val),
        .rd_req(rd_req), .re(re), .raddr(raddr), .rd_valid(rd_valid)
    );

    trb_ram #(.DEPTH(DEPTH), .AW(AW), .W(TRB_WORD_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(cap_data),
        .re(re), .raddr(raddr), .rdata(rd_data)
    );

    assign wr_ptr = waddr;
    // R9: non-empty once anything was captured since reset or re-arm
    assign status = {ovf, ovf || (waddr != '0)};

    assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wr_ptr) < DEPTH);
    assert_nonempty_after_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && cap_valid && !arm) |=> status[0]);
endmodule

// File: tb/sim_trace_ring_buf.sv
module sim_trace_ring_buf;
    localparam int DEPTH = 8;
    localparam int AW    = 3;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_en = 1'b0, cap_valid = 1'b0, arm = 1'b0;
    logic [31:0]   cap_data = '0;
    logic          rd_ptr_load = 1'b0, rd_req = 1'b0;
    logic [AW-1:0] rd_ptr_val = '0;
    logic [31:0]   rd_data;
    logic          rd_valid;
    logic [AW-1:0] wr_ptr;
    logic [1:0]    status;

    trace_ring_buf #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_valid(cap_valid),
        .cap_data(cap_data), .arm(arm), .rd_ptr_load(rd_ptr_load),
        .rd_ptr_val(rd_ptr_val), .rd_req(rd_req), .rd_data(rd_data),
        .rd_valid(rd_valid), .wr_ptr(wr_ptr), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;

    // reference model
    logic [31:0] mem_m [DEPTH];
    int          wr_m = 0;
    int          rp_m = 0;
    bit          ovf_m = 0;
    logic [31:0] hist [$];

    // scoreboard
    logic [31:0] exp_q [$];
    string       tag_q [$];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cap_model(input logic [31:0] d);
        mem_m[wr_m] = d;
        hist.push_back(d);
        if (wr_m == DEPTH-1) begin
            wr_m = 0;
            ovf_m = 1;
        end else begin
            wr_m++;
        end
    endtask

    task automatic capture(input logic [31:0] d);
        cap_valid = 1'b1;
        cap_data  = d;
        if (cap_en) cap_model(d);
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic load_rptr(input int v);
        rd_ptr_load = 1'b1;
        rd_ptr_val  = AW'(v);
        rp_m = v;
        @(negedge clk);
        rd_ptr_load = 1'b0;
    endtask

    task automatic host_read(input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_req = 1'b1;
        rp_m = (rp_m + 1) % DEPTH;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic check_wr_state(input string req);
        check(wr_ptr == AW'(wr_m), req, wr_ptr, wr_m);
        check(status == {ovf_m, ovf_m || (wr_m != 0)}, req, status,
              {ovf_m, ovf_m || (wr_m != 0)});
    endtask

    // R8: read the whole window and compare against capture history
    task automatic readout_oldest_first(input string tag);
        int start = ovf_m ? wr_m : 0;
        int n = ovf_m ? DEPTH : wr_m;
        load_rptr(start);
        for (int i = 0; i < n; i++) begin
            host_read(hist[hist.size() - n + i], tag);
        end
        @(negedge clk);
    endtask

    // monitor: pops expected words as the design returns them
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R5/R6 unexpected rd_valid", rd_data, 0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    task automatic run_test();
        logic [31:0] old;
        int a;
        repeat (2) @(negedge clk);
        // R1: reset state
        check(wr_ptr == '0, "R1 wr_ptr", wr_ptr, 0);
        check(status == 2'b00, "R1 status", status, 0);
        check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(status == 2'b00, "R9 empty status", status, 0);

        // R2 / R9: plain capture
        cap_en = 1'b1;
        for (int i = 0; i < 5; i++) capture(32'hA000_0000 + 32'(i));
        check_wr_state("R2 capture advance / R9");

        // R2: disabled capture has no effect
        cap_en = 1'b0;
        capture(32'hDEAD_BEEF);
        check_wr_state("R2 capture disabled");
        // R8: no wrap, oldest-first from address 0 (shows the ignored frame was not stored)
        readout_oldest_first("R8 no-wrap readout");

        // R3: wrap and overflow
        cap_en = 1'b1;
        for (int i = 0; i < 6; i++) capture(32'hB000_0000 + 32'(i));
        check_wr_state("R3 wrap sets overflow");
        check(status[1] == 1'b1, "R3 overflow bit", status[1], 1);
        capture(32'hB000_0100);
        check(status[1] == 1'b1, "R3 overflow sticky", status[1], 1);
        // R8 / R6: wrapped readout starting at wr_ptr, read pointer wraps
        readout_oldest_first("R8 wrapped readout");

        // R6: read pointer modulo wrap from DEPTH-1
        load_rptr(DEPTH-1);
        host_read(mem_m[DEPTH-1], "R6 read at last");
        host_read(mem_m[0], "R6 read wraps to 0");
        @(negedge clk);

        // R5: load and read same cycle, read ignored
        rd_ptr_load = 1'b1; rd_ptr_val = AW'(2); rd_req = 1'b1; rp_m = 2;
        @(negedge clk);
        rd_ptr_load = 1'b0; rd_req = 1'b0;
        check(rd_valid == 1'b0, "R5 read ignored on load", rd_valid, 0);
        host_read(mem_m[2], "R5 pointer loaded");
        @(negedge clk);

        // R7: capture and read same address same cycle returns old word
        a = wr_m;
        load_rptr(a);
        old = mem_m[a];
        exp_q.push_back(old);
        tag_q.push_back("R7 read-during-write old data");
        rd_req = 1'b1; cap_valid = 1'b1; cap_data = 32'hC0DE_0007;
        cap_model(32'hC0DE_0007);
        rp_m = (rp_m + 1) % DEPTH;
        @(negedge clk);
        rd_req = 1'b0; cap_valid = 1'b0;
        @(negedge clk);
        load_rptr(a);
        host_read(32'hC0DE_0007, "R7 new word stored");
        @(negedge clk);

        // R4: arm with a capture in the same cycle
        a = wr_m;
        old = mem_m[a];
        arm = 1'b1; cap_valid = 1'b1; cap_data = 32'hFFFF_0000;
        @(negedge clk);
        arm = 1'b0; cap_valid = 1'b0;
        wr_m = 0; ovf_m = 0; hist.delete();
        check_wr_state("R4 arm clears");
        load_rptr(a);
        host_read(old, "R4 dropped capture kept old word");
        @(negedge clk);

        // R8 after re-arm: fresh window from 0
        for (int i = 0; i < 3; i++) capture(32'hE000_0000 + 32'(i));
        check_wr_state("R9 after re-arm");
        readout_oldest_first("R8 readout after re-arm");
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
    endtask

    initial begin
        fork
            run_test();
            begin
                repeat (20000) @(posedge clk);
                check(0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule